// File: doc/BRIEF.md
# Store-Set Memory Dependence Predictor

This block predicts, for a load or store about to be scheduled, which older in-flight stores it has to wait for. A table indexed by instruction PC maps each PC to a store-set identifier. A second table, indexed by that identifier, keeps the sequence numbers of the most recently dispatched stores of each set. Memory-order violation reports train the PC table so that a load and the store it collided with end up in one set. Store dispatch fills the per-set slots. Store issue, squash and a periodic clear empty them again.

Each PC entry also has a strict flag. The flag is set when a violation names a load whose set already equals the store's set. Plain set membership evidently did not protect such a load. While the strict-wait configuration input is high, a lookup for a strict PC returns every store still pending anywhere, not just its own set. A bounded tracker of dispatched but unissued stores supplies that list. When the tracker is full, store dispatch is held off by a stall output.

Top module: `store_set_predictor`

## Requirements
- R1: The PC table index is PC bits [IDX_W+1:2], where IDX_W = log2(SSIT_DEPTH). Each entry holds a valid bit, a set ID and a strict flag. A lookup for a PC whose entry is not valid returns no sequence numbers.
- R2: A lookup raised on `lk_req_i` is answered in the following cycle, with `lk_vld_o` high. Each result slot k has a valid bit `lk_mask_o[k]` and a sequence number at `lk_seq_o[k*SEQ_W +: SEQ_W]`. In normal mode, slots 0 to LFST_WAYS-1 report the valid store slots of the PC's set. After reset `lk_vld_o` is low.
- R3: A violation in which neither the load PC nor the store PC has a valid entry gives both the same new set ID. That ID comes from a rotating counter that starts at 0 after reset and advances by one per such allocation. Both entries become valid and both strict flags are cleared.
- R4: A violation in which exactly one of the two PCs has a valid entry copies that entry's set ID into the other PC's entry. That entry becomes valid and its strict flag is cleared.
- R5: A violation in which both entries are valid keeps the smaller set ID. If the store's ID is larger, the store entry takes the load's ID and its strict flag is cleared. Otherwise the load entry takes the store's ID, and its strict flag becomes 1 exactly when the two IDs were already equal.
- R6: A dispatched store whose PC entry is valid writes its sequence number into the lowest free slot of its set. If all LFST_WAYS slots are valid, it overwrites the slot named by a per-set pointer. That pointer starts at 0 and advances by one on each overwrite. A store issue clears every slot that holds the issued sequence number.
- R7: Every accepted store dispatch enters the pending tracker, and the store's issue removes it. When `strict_en_i` is high and the looked-up PC's entry is valid and strict, the result lists every pending sequence number. When `strict_en_i` is low, the normal per-set result is returned.
- R8: When the pending tracker holds PEND_DEPTH entries, `stall_o` is high. A dispatch presented while it is high changes nothing and must be presented again later.
- R9: A squash removes every pending entry and every set slot whose sequence number is greater than the squash number, compared as unsigned values.
- R10: Every CLEAR_PERIOD cycles after reset, the block invalidates all PC entries, clears all strict flags, invalidates all set slots and empties the pending tracker.
- R11: A store issued in the same cycle as a lookup is left out of that lookup's result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| strict_en_i | input | 1 | Enables strict waiting for strict PCs |
| viol_vld_i | input | 1 | Violation report valid |
| viol_ld_pc_i | input | PC_W | PC of the violating load |
| viol_st_pc_i | input | PC_W | PC of the conflicting store |
| disp_vld_i | input | 1 | Store dispatch valid |
| disp_pc_i | input | PC_W | PC of the dispatched store |
| disp_seq_i | input | SEQ_W | Sequence number of the dispatched store |
| stall_o | output | 1 | Pending tracker full; dispatch not accepted |
| iss_vld_i | input | 1 | Store issue valid |
| iss_seq_i | input | SEQ_W | Sequence number of the issued store |
| sq_vld_i | input | 1 | Squash valid |
| sq_seq_i | input | SEQ_W | Squash sequence number; younger entries are removed |
| lk_req_i | input | 1 | Dependence lookup request |
| lk_pc_i | input | PC_W | PC to look up |
| lk_vld_o | output | 1 | Lookup result valid |
| lk_mask_o | output | PEND_DEPTH | Valid bit per result slot |
| lk_seq_o | output | PEND_DEPTH*SEQ_W | Sequence number per result slot |

## Verification
Violation, dispatch, issue and squash update state on the clock edge that samples them. A lookup presented in the next cycle sees that state, and its result is registered and appears one cycle after the request. `stall_o` follows the tracker occupancy as soon as the dispatch edge has passed. The bench drives every stimulus on a falling edge and releases it on the next falling edge. It reads lookup results on the falling edge after the request, which lies after the single result register. The periodic clear is checked only after the bench's own cycle count has passed the configured period, so its exact cycle does not matter.

// File: rtl/store_set_predictor.sv
module store_set_predictor #(
  parameter int PC_W         = 32,
  parameter int SEQ_W        = 16,
  parameter int SSIT_DEPTH   = 1024,
  parameter int LFST_DEPTH   = 16,
  parameter int LFST_WAYS    = 4,
  parameter int PEND_DEPTH   = 16,
  parameter int CLEAR_PERIOD = 250000
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        strict_en_i,
  input  logic                        viol_vld_i,
  input  logic [PC_W-1:0]             viol_ld_pc_i,
  input  logic [PC_W-1:0]             viol_st_pc_i,
  input  logic                        disp_vld_i,
  input  logic [PC_W-1:0]             disp_pc_i,
  input  logic [SEQ_W-1:0]            disp_seq_i,
  output logic                        stall_o,
  input  logic                        iss_vld_i,
  input  logic [SEQ_W-1:0]            iss_seq_i,
  input  logic                        sq_vld_i,
  input  logic [SEQ_W-1:0]            sq_seq_i,
  input  logic                        lk_req_i,
  input  logic [PC_W-1:0]             lk_pc_i,
  output logic                        lk_vld_o,
  output logic [PEND_DEPTH-1:0]       lk_mask_o,
  output logic [PEND_DEPTH*SEQ_W-1:0] lk_seq_o
);

  localparam int IDX_W = $clog2(SSIT_DEPTH);
  localparam int SID_W = $clog2(LFST_DEPTH);
  localparam int WAY_W = (LFST_WAYS > 1) ? $clog2(LFST_WAYS) : 1;
  localparam int PND_W = (PEND_DEPTH > 1) ? $clog2(PEND_DEPTH) : 1;
  localparam int CNT_W = $clog2(CLEAR_PERIOD + 1);

  // PC table
  logic [SSIT_DEPTH-1:0] ss_v, ss_strict;
  logic [SID_W-1:0]      ss_sid [SSIT_DEPTH];

  // per-set store slots
  logic [LFST_WAYS-1:0]  lf_v   [LFST_DEPTH];
  logic [SEQ_W-1:0]      lf_seq [LFST_DEPTH][LFST_WAYS];
  logic [WAY_W-1:0]      lf_vic [LFST_DEPTH];

  // pending-store tracker
  logic [PEND_DEPTH-1:0] pd_v;
  logic [SEQ_W-1:0]      pd_seq [PEND_DEPTH];

  logic [SID_W-1:0]      alloc_q;
  logic [CNT_W-1:0]      clr_cnt;
  logic                  clr_p;

  assign clr_p = (clr_cnt == CNT_W'(CLEAR_PERIOD - 1));

  always_ff @(posedge clk) begin
    if (!rst_n)     clr_cnt <= '0;
    else if (clr_p) clr_cnt <= '0;
    else            clr_cnt <= clr_cnt + 1'b1;
  end

  // ---------------- violation training ----------------
  logic [IDX_W-1:0] li, si;
  logic             lv, sv;
  logic [SID_W-1:0] lsid, ssid;
  logic             wr_ld, wr_st, ld_str_n, do_alloc;
  logic [SID_W-1:0] ld_sid_n, st_sid_n;

  assign li   = viol_ld_pc_i[IDX_W+1:2];
  assign si   = viol_st_pc_i[IDX_W+1:2];
  assign lv   = ss_v[li];
  assign sv   = ss_v[si];
  assign lsid = ss_sid[li];
  assign ssid = ss_sid[si];

  always_comb begin
    wr_ld    = 1'b0;
    wr_st    = 1'b0;
    ld_str_n = 1'b0;
    do_alloc = 1'b0;
    ld_sid_n = ssid;
    st_sid_n = lsid;
    unique case ({lv, sv})
      2'b00: begin
        wr_ld = 1'b1; wr_st = 1'b1; do_alloc = 1'b1;
        ld_sid_n = alloc_q; st_sid_n = alloc_q;
      end
      2'b01: wr_ld = 1'b1;
      2'b10: wr_st = 1'b1;
      default: begin
        if (ssid > lsid) wr_st = 1'b1;
        else begin
          wr_ld    = 1'b1;
          ld_str_n = (ssid == lsid);
        end
      end
    endcase
  end

  wire viol_go = viol_vld_i && !clr_p;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ss_v      <= '0;
      ss_strict <= '0;
      alloc_q   <= '0;
    end else if (clr_p) begin
      ss_v      <= '0;
      ss_strict <= '0;
    end else if (viol_vld_i) begin
      if (do_alloc) alloc_q <= alloc_q + 1'b1;
      if (wr_st) begin
        ss_v[si]      <= 1'b1;
        ss_strict[si] <= 1'b0;
      end
      if (wr_ld) begin
        ss_v[li]      <= 1'b1;
        ss_strict[li] <= ld_str_n;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (viol_go) begin
      if (wr_st) ss_sid[si] <= st_sid_n;
      if (wr_ld) ss_sid[li] <= ld_sid_n;
    end
  end

  // ---------------- store dispatch ----------------
  logic [IDX_W-1:0] di;
  logic [SID_W-1:0] d_set;
  logic             d_ok, d_lf, way_free;
  logic [WAY_W-1:0] way_ff, ins_way;
  logic             pd_full;
  logic [PND_W-1:0] pd_ff;

  assign di      = disp_pc_i[IDX_W+1:2];
  assign d_set   = ss_sid[di];
  assign pd_full = &pd_v;
  assign stall_o = pd_full;
  assign d_ok    = disp_vld_i && !pd_full && !clr_p;
  assign d_lf    = d_ok && ss_v[di];

  always_comb begin
    way_free = 1'b0;
    way_ff   = '0;
    for (int w = LFST_WAYS - 1; w >= 0; w--) begin
      if (!lf_v[d_set][w]) begin
        way_free = 1'b1;
        way_ff   = WAY_W'(w);
      end
    end
    pd_ff = '0;
    for (int k = PEND_DEPTH - 1; k >= 0; k--) begin
      if (!pd_v[k]) pd_ff = PND_W'(k);
    end
  end

  assign ins_way = way_free ? way_ff : lf_vic[d_set];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < LFST_DEPTH; s++) begin
        lf_v[s]   <= '0;
        lf_vic[s] <= '0;
      end
    end else begin
      for (int s = 0; s < LFST_DEPTH; s++) begin
        for (int w = 0; w < LFST_WAYS; w++) begin
          if (clr_p) begin
            lf_v[s][w] <= 1'b0;
          end else if (d_lf && d_set == SID_W'(s) && ins_way == WAY_W'(w)) begin
            lf_v[s][w]   <= 1'b1;
            lf_seq[s][w] <= disp_seq_i;
          end else if ((iss_vld_i && lf_seq[s][w] == iss_seq_i) ||
                       (sq_vld_i && lf_seq[s][w] > sq_seq_i)) begin
            lf_v[s][w] <= 1'b0;
          end
        end
        if (d_lf && !way_free && d_set == SID_W'(s)) begin
          lf_vic[s] <= (lf_vic[s] == WAY_W'(LFST_WAYS - 1)) ? '0 : lf_vic[s] + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pd_v <= '0;
    end else begin
      for (int k = 0; k < PEND_DEPTH; k++) begin
        if (clr_p) begin
          pd_v[k] <= 1'b0;
        end else if (d_ok && pd_ff == PND_W'(k)) begin
          pd_v[k]   <= 1'b1;
          pd_seq[k] <= disp_seq_i;
        end else if ((iss_vld_i && pd_seq[k] == iss_seq_i) ||
                     (sq_vld_i && pd_seq[k] > sq_seq_i)) begin
          pd_v[k] <= 1'b0;
        end
      end
    end
  end

  // ---------------- lookup ----------------
  logic [IDX_W-1:0]          qi;
  logic [SID_W-1:0]          q_set;
  logic                      q_strict;
  logic [PEND_DEPTH-1:0]     q_mask;
  logic [PEND_DEPTH*SEQ_W-1:0] q_seq;

  assign qi       = lk_pc_i[IDX_W+1:2];
  assign q_set    = ss_sid[qi];
  assign q_strict = strict_en_i && ss_v[qi] && ss_strict[qi];

  for (genvar k = 0; k < PEND_DEPTH; k++) begin : g_slot
    if (k < LFST_WAYS) begin : g_way
      wire [SEQ_W-1:0] nseq = lf_seq[q_set][k];
      wire             nv   = ss_v[qi] && lf_v[q_set][k];
      assign q_seq[k*SEQ_W +: SEQ_W] = q_strict ? pd_seq[k] : nseq;
      assign q_mask[k] = q_strict ? (pd_v[k] && !(iss_vld_i && pd_seq[k] == iss_seq_i))
                                  : (nv && !(iss_vld_i && nseq == iss_seq_i));
    end else begin : g_pend
      assign q_seq[k*SEQ_W +: SEQ_W] = pd_seq[k];
      assign q_mask[k] = q_strict && pd_v[k] && !(iss_vld_i && pd_seq[k] == iss_seq_i);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lk_vld_o  <= 1'b0;
      lk_mask_o <= '0;
      lk_seq_o  <= '0;
    end else begin
      lk_vld_o  <= lk_req_i;
      lk_mask_o <= lk_req_i ? q_mask : '0;
      lk_seq_o  <= q_seq;
    end
  end

  // ---------------- assertions ----------------
  assert_lookup_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    lk_req_i |=> lk_vld_o);

  assert_fresh_pair_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (viol_vld_i && !clr_p && !lv && !sv) |=>
      (ss_v[$past(li)] && ss_v[$past(si)] && ss_sid[$past(li)] == ss_sid[$past(si)]));

  assert_equal_sets_strict_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (viol_vld_i && !clr_p && lv && sv && lsid == ssid) |=> ss_strict[$past(li)]);

  assert_normal_width_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_vld_o && !$past(strict_en_i)) |-> ($countones(lk_mask_o) <= LFST_WAYS));

  assert_stall_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_o && disp_vld_i && !iss_vld_i && !sq_vld_i && !clr_p) |=> (pd_v == $past(pd_v)));

  assert_clear_empties_R10: assert property (@(posedge clk) disable iff (!rst_n)
    clr_p |=> (pd_v == '0 && ss_v == '0 && !stall_o));

endmodule

// File: tb/store_set_predictor_tb.sv
module store_set_predictor_tb_top;
  localparam int SEQ_W = 16;
  localparam int PEND  = 16;
  localparam int PER   = 3000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic strict_en = 1'b1;
  logic viol_vld = 1'b0;
  logic [31:0] viol_ld = '0, viol_st = '0;
  logic disp_vld = 1'b0;
  logic [31:0] disp_pc = '0;
  logic [SEQ_W-1:0] disp_seq = '0;
  logic stall;
  logic iss_vld = 1'b0;
  logic [SEQ_W-1:0] iss_seq = '0;
  logic sq_vld = 1'b0;
  logic [SEQ_W-1:0] sq_seq = '0;
  logic lk_req = 1'b0;
  logic [31:0] lk_pc = '0;
  logic lk_vld;
  logic [PEND-1:0] lk_mask;
  logic [PEND*SEQ_W-1:0] lk_seq;

  int vectors = 0, miscompares = 0, cyc = 0;
  bit done = 1'b0;
  int exp_q[$];

  localparam logic [31:0] PA = 32'h104, PB = 32'h208, PC = 32'h30C, PD = 32'h410,
                          PE = 32'h514, PF = 32'h618, PG = 32'h71C;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  store_set_predictor #(.SEQ_W(SEQ_W), .PEND_DEPTH(PEND), .CLEAR_PERIOD(PER)) dut_i (
    .clk(clk), .rst_n(rst_n), .strict_en_i(strict_en),
    .viol_vld_i(viol_vld), .viol_ld_pc_i(viol_ld), .viol_st_pc_i(viol_st),
    .disp_vld_i(disp_vld), .disp_pc_i(disp_pc), .disp_seq_i(disp_seq), .stall_o(stall),
    .iss_vld_i(iss_vld), .iss_seq_i(iss_seq), .sq_vld_i(sq_vld), .sq_seq_i(sq_seq),
    .lk_req_i(lk_req), .lk_pc_i(lk_pc), .lk_vld_o(lk_vld), .lk_mask_o(lk_mask), .lk_seq_o(lk_seq));

  task automatic check_bit(input logic got, input logic exp, input string tag);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s: got %b expected %b", tag, got, exp);
    end
  endtask

  task automatic verify_result(input string tag);
    bit bad;
    int got;
    got = $countones(lk_mask);
    bad = (lk_vld !== 1'b1) || (got != exp_q.size());
    foreach (exp_q[i]) begin
      bit hit = 1'b0;
      for (int k = 0; k < PEND; k++)
        if (lk_mask[k] && lk_seq[k*SEQ_W +: SEQ_W] == SEQ_W'(exp_q[i])) hit = 1'b1;
      if (!hit) bad = 1'b1;
    end
    vectors++;
    if (bad) begin
      miscompares++;
      $display("FAIL %s: got vld=%b %0d entries mask=%h, expected %0d entries %p",
               tag, lk_vld, got, lk_mask, exp_q.size(), exp_q);
    end
  endtask

  task automatic lookup(input logic [31:0] pc, input logic en, input string tag);
    @(negedge clk); lk_req = 1'b1; lk_pc = pc; strict_en = en;
    @(negedge clk); lk_req = 1'b0; strict_en = 1'b1;
    verify_result(tag);
  endtask

  task automatic violate(input logic [31:0] ld, input logic [31:0] st);
    @(negedge clk); viol_vld = 1'b1; viol_ld = ld; viol_st = st;
    @(negedge clk); viol_vld = 1'b0;
  endtask

  task automatic dispatch(input logic [31:0] pc, input int seq);
    @(negedge clk); disp_vld = 1'b1; disp_pc = pc; disp_seq = SEQ_W'(seq);
    @(negedge clk); disp_vld = 1'b0;
  endtask

  task automatic issue(input int seq);
    @(negedge clk); iss_vld = 1'b1; iss_seq = SEQ_W'(seq);
    @(negedge clk); iss_vld = 1'b0;
  endtask

  task automatic squash(input int seq);
    @(negedge clk); sq_vld = 1'b1; sq_seq = SEQ_W'(seq);
    @(negedge clk); sq_vld = 1'b0;
  endtask

  task automatic t_reset;
    check_bit(lk_vld, 1'b0, "R2 reset lk_vld");
    check_bit(stall, 1'b0, "R8 reset stall");
    exp_q = {}; lookup(PC, 1'b1, "R1 invalid entry empty");
  endtask

  task automatic t_fresh;
    violate(PA, PB);
    dispatch(PB, 10);
    exp_q = {10}; lookup(PA, 1'b1, "R3 load sees set store");
    exp_q = {10}; lookup(PB, 1'b1, "R3 store sees own set");
    issue(10);
    exp_q = {}; lookup(PA, 1'b1, "R6 issue clears slot");
  endtask

  task automatic t_one_valid;
    violate(PC, PB);
    dispatch(PB, 11);
    exp_q = {11}; lookup(PC, 1'b1, "R4 load joins store set");
    violate(PA, PD);
    dispatch(PD, 12);
    exp_q = {11, 12}; lookup(PA, 1'b1, "R4 store joins load set");
    squash(0);
  endtask

  task automatic t_strict;
    violate(PA, PB);
    dispatch(PE, 20);
    dispatch(PB, 21);
    exp_q = {20, 21}; lookup(PA, 1'b1, "R7 strict waits all pending");
    exp_q = {21};     lookup(PA, 1'b0, "R7 strict disabled normal");
  endtask

  task automatic t_merge;
    violate(PF, PG);
    dispatch(PG, 22);
    exp_q = {22}; lookup(PF, 1'b1, "R3 second fresh id");
    exp_q = {21}; lookup(PA, 1'b0, "R3 ids distinct");
    violate(PF, PB);
    exp_q = {21}; lookup(PF, 1'b1, "R5 load takes smaller id non strict");
    violate(PF, PG);
    dispatch(PG, 23);
    exp_q = {21, 23}; lookup(PF, 1'b1, "R5 store takes smaller id");
    exp_q = {20, 21, 22, 23}; lookup(PA, 1'b1, "R7 strict all pending");
    squash(0);
    exp_q = {}; lookup(PA, 1'b1, "R9 squash all");
  endtask

  task automatic t_partial_squash;
    dispatch(PB, 30); dispatch(PB, 31); dispatch(PB, 32);
    squash(30);
    exp_q = {30}; lookup(PF, 1'b1, "R9 slots younger removed");
    exp_q = {30}; lookup(PA, 1'b1, "R9 pending younger removed");
    squash(0);
  endtask

  task automatic t_overflow;
    for (int s = 40; s <= 44; s++) dispatch(PB, s);
    exp_q = {41, 42, 43, 44}; lookup(PF, 1'b1, "R6 victim way 0 replaced");
    exp_q = {40, 41, 42, 43, 44}; lookup(PA, 1'b1, "R7 pending keeps evicted");
  endtask

  task automatic t_issue_first;
    @(negedge clk); lk_req = 1'b1; lk_pc = PF; iss_vld = 1'b1; iss_seq = 16'd42;
    @(negedge clk); lk_req = 1'b0; iss_vld = 1'b0;
    exp_q = {41, 43, 44}; verify_result("R11 same cycle issue excluded");
    exp_q = {41, 43, 44}; lookup(PF, 1'b1, "R6 issued slot gone");
  endtask

  task automatic t_stall;
    squash(0);
    for (int s = 50; s <= 65; s++) dispatch(PE, s);
    check_bit(stall, 1'b1, "R8 stall when full");
    dispatch(PE, 66);
    issue(50);
    check_bit(stall, 1'b0, "R8 stall released");
    exp_q = {};
    for (int s = 51; s <= 65; s++) exp_q.push_back(s);
    lookup(PA, 1'b1, "R8 stalled dispatch dropped");
    squash(0);
  endtask

  task automatic t_clear;
    dispatch(PE, 80);
    exp_q = {80}; lookup(PA, 1'b1, "R10 before clear");
    while (cyc < PER + 20) @(negedge clk);
    check_bit(stall, 1'b0, "R10 stall after clear");
    exp_q = {}; lookup(PA, 1'b1, "R10 pending and entry cleared");
    dispatch(PB, 81);
    exp_q = {}; lookup(PF, 1'b0, "R10 entries invalid");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_fresh();
    t_one_valid();
    t_strict();
    t_merge();
    t_partial_squash();
    t_overflow();
    t_issue_first();
    t_stall();
    t_clear();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    #(20 * 20000);
    if (!done) begin
      done = 1'b1;
      vectors++;
      miscompares++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule